// File: doc/BRIEF.md
# First-Order Passive Sigma-Delta Modulator Model

This block is a cycle-stepped, fixed-point model of a first-order sigma-delta modulator built around a passive RC integrator. It holds one integrator voltage as state. On every step it charges that voltage toward the sum of the input voltage and a feedback voltage, with a leak term that pulls it back by twice its own value. The feedback voltage is the inverse of the current output bit, taken at full scale. The new integrator voltage is then compared against mid-supply, and the result becomes the next output bit.

Voltages are unsigned Q1.15 numbers, so full scale (the supply, normalised to 1.0) is 32768 and mid-supply is 16384. The step gain is the clock period divided by the RC product, also given in Q1.15. The default gain of 0.05 is 1638. A gain of one half or more would let the integrator leave the supply range, so such a gain is flagged and the step is refused. A surrounding test or modelling environment feeds one input sample per valid strobe. It reads the bit stream and the integrator level.

Top module: `sd_passive_mod`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the integrator output reads 16384 (0.5) and the output bit reads 0.
- R2: On each clock edge where the strobe is high and the gain is accepted, the integrator becomes V + round(k·(F + X − 2·V) / 32768). V is the previous integrator value, k is the gain and X is the clamped input. F is 32768 when the current bit is 0 and 0 when the bit is 1. The new value appears one cycle after the strobe.
- R3: The scaled step is rounded to nearest, with exact halves rounded toward plus infinity. From the reset state, gain 8192 with input 2 gives exactly 16385.
- R4: The output bit is registered with the new integrator value. It is 1 only when that value is strictly greater than 16384, so a value of exactly 16384 gives 0.
- R5: On an edge where the strobe is low, the integrator and the bit keep their values whatever the other inputs are.
- R6: The gain-invalid output is 1 in the same cycle whenever the gain input is 16384 (0.5) or larger, and 0 otherwise. An update strobed with such a gain changes neither the integrator nor the bit.
- R7: Input values above 32768 act exactly as 32768.
- R8: The integrator output never exceeds 32768. A computed value below 0 or above 32768 is saturated to that limit.
- R9: With input 9830 (0.3) and gain 1638 (0.05), strobed every cycle from reset, the integrator reads 16384, 16875, 15679, 16241, 16747 and the bit reads 0, 1, 0, 0, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vin_i | input | 16 | Input voltage, unsigned Q1.15 |
| gain_i | input | 16 | Step gain (period over RC), unsigned Q1.15 |
| valid_i | input | 1 | Step strobe; one update per high cycle |
| bit_o | output | 1 | Modulator output bit |
| integ_o | output | 16 | Current integrator voltage, unsigned Q1.15 |
| gain_bad_o | output | 1 | Gain is 0.5 or above; update refused |

## Verification
The integrator value and the output bit are due one cycle after the strobe edge that produced them, because both come from the same register. The gain-invalid flag is combinational and is due in the same cycle as the gain input. The bench drives each stimulus two nanoseconds after a rising edge and advances its reference model once per edge. It compares the registered outputs two nanoseconds after the following edge and checks the flag before that edge, while the stimulus is still applied.

// File: rtl/sd_pkg.sv
package sd_pkg;
    // Default number format: unsigned Q1.15 in a 16-bit word
    localparam int SD_DW   = 16;
    localparam int SD_FRAC = 15;

    // Headroom bits for the signed feedback/input/leak difference
    localparam int SD_DIFF_GUARD = 3;
endpackage

// File: rtl/sd_diff_former.sv
// Forms the signed drive term F + X - 2V for one integrator step.
module sd_diff_former #(
    parameter int DW     = sd_pkg::SD_DW,
    parameter int FRAC   = sd_pkg::SD_FRAC,
    parameter int DIFF_W = DW + sd_pkg::SD_DIFF_GUARD
) (
    input  logic [DW-1:0]            vin,
    input  logic [DW-1:0]            integ,
    input  logic                     out_bit,
    output logic signed [DIFF_W-1:0] diff
);
    localparam logic [DW-1:0] FULL  = DW'(1) << FRAC;
    localparam int            EXT_W = DIFF_W - DW;

    logic [DW-1:0] vin_c;
    logic [DW-1:0] fb_lvl;
    logic signed [DIFF_W-1:0] fb_ext;
    logic signed [DIFF_W-1:0] vin_ext;
    logic signed [DIFF_W-1:0] leak_ext;

    always_comb begin
        // input above full scale is treated as full scale
        vin_c    = (vin > FULL) ? FULL : vin;
        // inverted output bit drives the feedback resistor
        fb_lvl   = out_bit ? '0 : FULL;
        fb_ext   = $signed({{EXT_W{1'b0}}, fb_lvl});
        vin_ext  = $signed({{EXT_W{1'b0}}, vin_c});
        leak_ext = $signed({{(EXT_W-1){1'b0}}, integ, 1'b0});
        diff     = fb_ext + vin_ext - leak_ext;
    end
endmodule

// File: rtl/sd_gain_scale.sv
// Multiplies the drive term by the step gain and rounds back to Q1.15.
module sd_gain_scale #(
    parameter int DW     = sd_pkg::SD_DW,
    parameter int FRAC   = sd_pkg::SD_FRAC,
    parameter int DIFF_W = DW + sd_pkg::SD_DIFF_GUARD,
    parameter int PROD_W = DIFF_W + DW + 1
) (
    input  logic signed [DIFF_W-1:0] diff,
    input  logic [DW-1:0]            gain,
    output logic signed [PROD_W-1:0] delta
);
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC - 1);

    logic signed [PROD_W-1:0] diff_ext;
    logic signed [PROD_W-1:0] gain_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;

    always_comb begin
        diff_ext = {{(PROD_W-DIFF_W){diff[DIFF_W-1]}}, diff};
        gain_ext = $signed({{(PROD_W-DW){1'b0}}, gain});
        prod     = diff_ext * gain_ext;
        // round to nearest, halves toward plus infinity
        biased   = prod + HALF_LSB;
        delta    = biased >>> FRAC;
    end
endmodule

// File: rtl/sd_limit_slice.sv
// Adds the step, saturates to the supply range and slices at mid-supply.
module sd_limit_slice #(
    parameter int DW     = sd_pkg::SD_DW,
    parameter int FRAC   = sd_pkg::SD_FRAC,
    parameter int PROD_W = 2 * DW + sd_pkg::SD_DIFF_GUARD + 1
) (
    input  logic [DW-1:0]            integ,
    input  logic signed [PROD_W-1:0] delta,
    output logic [DW-1:0]            integ_nx,
    output logic                     bit_nx
);
    localparam logic [DW-1:0]            FULL   = DW'(1) << FRAC;
    localparam logic [DW-1:0]            MID    = DW'(1) << (FRAC - 1);
    localparam logic signed [PROD_W-1:0] FULL_W = PROD_W'(1) << FRAC;

    logic signed [PROD_W-1:0] sum;

    always_comb begin
        sum = $signed({{(PROD_W-DW){1'b0}}, integ}) + delta;
        if (sum < 0) begin
            integ_nx = '0;
        end else if (sum > FULL_W) begin
            integ_nx = FULL;
        end else begin
            integ_nx = sum[DW-1:0];
        end
        // strictly above mid-supply reads as one
        bit_nx = (integ_nx > MID);
    end
endmodule

// File: rtl/sd_passive_mod.sv
// First-order passive RC sigma-delta modulator, one step per strobe.
module sd_passive_mod #(
    parameter int DW   = sd_pkg::SD_DW,
    parameter int FRAC = sd_pkg::SD_FRAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] vin_i,
    input  logic [DW-1:0] gain_i,
    input  logic          valid_i,
    output logic          bit_o,
    output logic [DW-1:0] integ_o,
    output logic          gain_bad_o
);
    localparam int            DIFF_W   = DW + sd_pkg::SD_DIFF_GUARD;
    localparam int            PROD_W   = DIFF_W + DW + 1;
    localparam logic [DW-1:0] MID      = DW'(1) << (FRAC - 1);
    localparam logic [DW-1:0] GAIN_LIM = DW'(1) << (FRAC - 1);

    typedef struct packed {
        logic [DW-1:0] integ;
        logic          out_bit;
    } mod_state_t;

    mod_state_t state_d, state_q;

    logic signed [DIFF_W-1:0] drive;
    logic signed [PROD_W-1:0] step;
    logic [DW-1:0]            integ_cand;
    logic                     bit_cand;
    logic                     gain_bad;

    sd_diff_former #(
        .DW(DW), .FRAC(FRAC), .DIFF_W(DIFF_W)
    ) u_diff (
        .vin     (vin_i),
        .integ   (state_q.integ),
        .out_bit (state_q.out_bit),
        .diff    (drive)
    );

    sd_gain_scale #(
        .DW(DW), .FRAC(FRAC), .DIFF_W(DIFF_W), .PROD_W(PROD_W)
    ) u_scale (
        .diff  (drive),
        .gain  (gain_i),
        .delta (step)
    );

    sd_limit_slice #(
        .DW(DW), .FRAC(FRAC), .PROD_W(PROD_W)
    ) u_limit (
        .integ    (state_q.integ),
        .delta    (step),
        .integ_nx (integ_cand),
        .bit_nx   (bit_cand)
    );

    always_comb begin
        gain_bad = (gain_i >= GAIN_LIM);
        state_d  = state_q;
        if (valid_i && !gain_bad) begin
            state_d.integ   = integ_cand;
            state_d.out_bit = bit_cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.integ   <= MID;
            state_q.out_bit <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign integ_o    = state_q.integ;
    assign bit_o      = state_q.out_bit;
    assign gain_bad_o = gain_bad;
endmodule

// File: rtl/sd_passive_mod_chk.sv
// Property checker attached to the modulator top.
module sd_passive_mod_chk #(
    parameter int DW   = sd_pkg::SD_DW,
    parameter int FRAC = sd_pkg::SD_FRAC
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] gain_i,
    input logic          valid_i,
    input logic          bit_o,
    input logic [DW-1:0] integ_o
);
    localparam logic [DW-1:0] FULL = DW'(1) << FRAC;
    localparam logic [DW-1:0] MID  = DW'(1) << (FRAC - 1);

    AST_RESET_MID: assert property (@(posedge clk) !rst_n |=> (integ_o == MID) && !bit_o); // R1
    AST_BIT_SLICE: assert property (@(posedge clk) disable iff (!rst_n) bit_o == (integ_o > MID)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !valid_i |=> $stable(integ_o) && $stable(bit_o)); // R5
    AST_BAD_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (valid_i && (gain_i >= MID)) |=> $stable(integ_o) && $stable(bit_o)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) integ_o <= FULL); // R8
endmodule

bind sd_passive_mod sd_passive_mod_chk #(.DW(DW), .FRAC(FRAC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gain_i  (gain_i),
    .valid_i (valid_i),
    .bit_o   (bit_o),
    .integ_o (integ_o)
);

// File: tb/sd_passive_mod_test.sv
module sd_passive_mod_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] vin_i = '0;
    logic [15:0] gain_i = '0;
    logic        valid_i = 1'b0;
    logic        bit_o;
    logic [15:0] integ_o;
    logic        gain_bad_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference state
    longint m_v = 16384;
    longint m_b = 0;

    always #4 clk = ~clk;   // 125 MHz

    sd_passive_mod uut (
        .clk(clk), .rst_n(rst_n), .vin_i(vin_i), .gain_i(gain_i),
        .valid_i(valid_i), .bit_o(bit_o), .integ_o(integ_o), .gain_bad_o(gain_bad_o)
    );

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint floor_div(longint num, longint den);
        if (num >= 0) return num / den;
        return -((-num + den - 1) / den);
    endfunction

    // reference for one clock edge with the given inputs
    task automatic model_edge(longint vin, longint k, bit vld);
        longint x, f, d, nv;
        if (vld && k < 16384) begin
            x  = (vin > 32768) ? 32768 : vin;
            f  = (m_b == 1) ? 0 : 32768;
            d  = f + x - 2 * m_v;
            nv = m_v + floor_div(d * k + 16384, 32768);
            if (nv < 0) nv = 0;
            if (nv > 32768) nv = 32768;
            m_v = nv;
            m_b = (nv > 16384) ? 1 : 0;
        end
    endtask

    // apply inputs, check the flag before the edge, then the registers after it
    task automatic step(longint vin, longint k, bit vld, string tag);
        vin_i   = 16'(vin);
        gain_i  = 16'(k);
        valid_i = vld;
        #1;
        check({tag, "/R6 flag"}, gain_bad_o, (k >= 16384) ? 1 : 0);
        @(posedge clk);
        model_edge(vin, k, vld);
        #2;
        check({tag, " integ"}, integ_o, m_v);
        check({tag, " bit"}, bit_o, m_b);
        check("R8 range", (integ_o <= 16'd32768) ? 1 : 0, 1);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        valid_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        check("R1 integ in reset", integ_o, 16384);
        check("R1 bit in reset", bit_o, 0);
        rst_n = 1'b1;
        m_v = 16384;
        m_b = 0;
        @(posedge clk);
        #2;
        check("R1 integ after reset", integ_o, 16384);
        check("R1 bit after reset", bit_o, 0);
    endtask

    longint exp_v[5] = '{16384, 16875, 15679, 16241, 16747};
    longint exp_b[5] = '{0, 1, 0, 0, 1};

    initial begin
        do_reset();

        // R9 worked sequence, also R2 against the model
        for (int i = 1; i < 5; i++) begin
            step(9830, 1638, 1'b1, "R2 seq");
            check("R9 integ", integ_o, exp_v[i]);
            check("R9 bit", bit_o, exp_b[i]);
        end

        // R5 strobe low: no change whatever the inputs
        step(32768, 1638, 1'b0, "R5 idle");
        check("R5 integ held", integ_o, exp_v[4]);
        step(0, 9000, 1'b0, "R5 idle");
        check("R5 integ held", integ_o, exp_v[4]);

        // R6 gain of 0.5 and above refused
        step(9830, 16384, 1'b1, "R6 bad gain");
        check("R6 integ held", integ_o, exp_v[4]);
        step(0, 65535, 1'b1, "R6 bad gain");
        check("R6 integ held", integ_o, exp_v[4]);
        check("R6 bit held", bit_o, 1);
        step(9830, 16383, 1'b1, "R6 edge gain");

        // R4 exactly mid-supply slices to zero
        do_reset();
        step(0, 1638, 1'b1, "R4 mid");
        check("R4 integ at mid", integ_o, 16384);
        check("R4 bit at mid", bit_o, 0);

        // R3 half rounds up: +0.5 LSB
        do_reset();
        step(2, 8192, 1'b1, "R3 tie");
        check("R3 tie value", integ_o, 16385);
        check("R4 bit above mid", bit_o, 1);

        // R7 input above full scale clamps
        do_reset();
        for (int i = 0; i < 6; i++) step(65535, 6000, 1'b1, "R7 clamp");
        for (int i = 0; i < 6; i++) step(40000, 12000, 1'b1, "R7 clamp");

        // mixed patterns, including extreme gains near the limit
        for (int i = 0; i < 400; i++) begin
            longint v = $urandom_range(0, 36000);
            longint k = ($urandom_range(0, 9) == 0) ? $urandom_range(16384, 65535)
                                                   : $urandom_range(0, 16383);
            step(v, k, ($urandom_range(0, 3) != 0), "R2 mixed");
        end
        for (int i = 0; i < 40; i++) step(32768, 16383, 1'b1, "R8 stress");
        for (int i = 0; i < 40; i++) step(0, 16383, 1'b1, "R8 stress");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule